// File: doc/BRIEF.md
# SDRAM Write Burst Sequencer

This block sits on the controller side of an SDRAM interface. It turns write requests into WRITE commands on the command pins and drives the data bus for each fixed-length burst. A request names a bank, a starting column and whether the row should be precharged automatically when the burst ends. The data words come in on a separate stream. The block assumes the target row is already open. Activation, refresh, reads, mode programming and power-up sequencing are handled elsewhere.

The first word of a burst leaves in the same cycle as its WRITE command. Each later word leaves on the next edge. A new request can be accepted on any cycle. It cuts off the burst in progress with no idle cycle and no even-cycle alignment rule, and a burst can also follow the previous one back-to-back. All pin outputs are registered. The bus is modelled as a drive value plus an output enable, and the pad turns that into high impedance.

Back-pressure rules are as follows. A request is taken only together with its first data word, so `req_ready` follows `dat_valid`. A waiting request therefore never starts a burst that would lack its opening word. `dat_ready` is high while burst beats remain and whenever a request is offered. The requester should supply one word per remaining beat. If it misses a beat, that beat is left undriven and the burst still ends on schedule, because the device counts beats on its own.

Top module: `sdram_wr_seq`

## Requirements
- R1: While reset is active and after it is released, the pins show NOP (chip select low, row strobe, column strobe and write enable high), output enable is low and no close pulse is given.
- R2: A request is accepted at an edge where `req_valid` and `dat_valid` are both high. In the next cycle the pins show WRITE (chip select low, row strobe high, column strobe low, write enable low). In that same cycle `sd_ba` carries the bank, `sd_addr` carries the column in bits 0 to COL_W-1, bit 10 carries the auto-precharge flag, the other address bits are zero, `sd_dq_out` carries the first word and `sd_dq_oe` is high.
- R3: In the BURST_LEN-1 cycles after a WRITE, the pins show NOP and each cycle drives the next stream word in order, with output enable high.
- R4: Once all beats are done and no request is accepted, output enable is low and `dat_ready` is low, so offered words are not consumed.
- R5: A request accepted while beats remain issues its WRITE in the very next cycle with its own first word, and the beat count restarts from the full burst length.
- R6: A request accepted at the edge that ends the final beat places its WRITE and first word in the next cycle, directly after the final beat, with no gap.
- R7: When an auto-precharge burst runs all BURST_LEN beats, `ap_close_valid` is high for one cycle, in the cycle after the final beat, with that burst's bank on `ap_close_bank`. A burst cut short by a new request gives no close pulse.
- R8: If `dat_valid` is low during a remaining beat, that beat has output enable low, and the burst still ends at its scheduled cycle.
- R9: `req_ready` equals `dat_valid`. A request offered without data issues no command and stays pending.
- R10: `sd_cke` is high at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Write request offered |
| req_ready | output | 1 | Request accepted this edge (with first word) |
| req_bank | input | BANK_W | Target bank |
| req_col | input | COL_W | Starting column |
| req_autopre | input | 1 | Precharge row when burst completes |
| dat_valid | input | 1 | Data word offered |
| dat_ready | output | 1 | Data word consumed this edge |
| dat_word | input | DATA_W | Data word |
| sd_cke | output | 1 | Clock enable, held high |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BANK_W | Bank address |
| sd_addr | output | ADDR_W | Address bus |
| sd_dq_out | output | DATA_W | Data bus drive value |
| sd_dq_oe | output | 1 | Data bus drive enable |
| ap_close_valid | output | 1 | Bank closed by auto precharge |
| ap_close_bank | output | BANK_W | Bank that was closed |

## Verification
The request stream is tried in several patterns:
- **Isolated burst, no auto-precharge.** Shows the same-cycle word placement and the release of the bus afterwards.
- **Isolated burst with auto-precharge.** Shows the close pulse and its bank.
- **Truncating request mid-burst.** Separates a restarting counter from one that runs on, and checks that the cut-off burst gives no close pulse.
- **Back-to-back request at the last beat.** Exposes any bubble between bursts.
- **Starved beat and a request without data.** Show that the beat count is independent of data arrival and that stalled requests issue nothing.

// File: rtl/sdram_wr_pkg.sv
package sdram_wr_pkg;
  typedef enum logic {
    CMD_NOP   = 1'b0,
    CMD_WRITE = 1'b1
  } wcmd_e;

  // pin order {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] PINS_NOP   = 4'b0111;
  localparam logic [3:0] PINS_WRITE = 4'b0100;
endpackage

// File: rtl/sdram_wr_cmd_enc.sv
module sdram_wr_cmd_enc
  import sdram_wr_pkg::*;
(
  input  wcmd_e      cmd,
  output logic [3:0] pins
);
  always_comb begin
    unique case (cmd)
      CMD_WRITE: pins = PINS_WRITE;
      default:   pins = PINS_NOP;
    endcase
  end
endmodule

// File: rtl/sdram_wr_beat_ctr.sv
module sdram_wr_beat_ctr #(
  parameter int BURST_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic more_beats,
  output logic last_beat
);
  localparam int CNT_W = $clog2(BURST_LEN) + 1;
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(BURST_LEN - 1);

  logic [CNT_W-1:0] rem_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q     <= '0;
      last_beat <= 1'b0;
    end else if (start) begin
      rem_q     <= RELOAD;
      last_beat <= (BURST_LEN == 1);
    end else if (rem_q != '0) begin
      rem_q     <= rem_q - 1'b1;
      last_beat <= (rem_q == CNT_W'(1));
    end else begin
      last_beat <= 1'b0;
    end
  end

  assign more_beats = (rem_q != '0);

  a_r3_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    rem_q <= RELOAD);

  a_r5_reload_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (rem_q == RELOAD));
endmodule

// File: rtl/sdram_wr_close_trk.sv
module sdram_wr_close_trk #(
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BANK_W-1:0] start_bank,
  input  logic              start_ap,
  input  logic              last_beat,
  output logic              close_valid,
  output logic [BANK_W-1:0] close_bank
);
  logic              ap_q;
  logic [BANK_W-1:0] bank_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ap_q        <= 1'b0;
      bank_q      <= '0;
      close_valid <= 1'b0;
      close_bank  <= '0;
    end else begin
      if (start) begin
        ap_q   <= start_ap;
        bank_q <= start_bank;
      end
      close_valid <= last_beat & ap_q;
      close_bank  <= bank_q;
    end
  end
endmodule

// File: rtl/sdram_wr_seq.sv
module sdram_wr_seq
  import sdram_wr_pkg::*;
#(
  parameter int BURST_LEN = 4,
  parameter int BANK_W    = 2,
  parameter int COL_W     = 9,
  parameter int ADDR_W    = 13,
  parameter int AP_BIT    = 10,
  parameter int DATA_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [COL_W-1:0]  req_col,
  input  logic              req_autopre,
  input  logic              dat_valid,
  output logic              dat_ready,
  input  logic [DATA_W-1:0] dat_word,
  output logic              sd_cke,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [BANK_W-1:0] sd_ba,
  output logic [ADDR_W-1:0] sd_addr,
  output logic [DATA_W-1:0] sd_dq_out,
  output logic              sd_dq_oe,
  output logic              ap_close_valid,
  output logic [BANK_W-1:0] ap_close_bank
);
  logic              start;
  logic              more_beats;
  logic              last_beat;
  wcmd_e             cmd_d;
  logic [3:0]        pins_d;
  logic [3:0]        pins_q;
  logic [ADDR_W-1:0] addr_d;

  // a request only goes with its opening data word
  assign req_ready = dat_valid;
  assign start     = req_valid & dat_valid;
  assign dat_ready = more_beats | req_valid;
  assign sd_cke    = 1'b1;

  assign cmd_d = start ? CMD_WRITE : CMD_NOP;

  sdram_wr_cmd_enc u_enc (
    .cmd  (cmd_d),
    .pins (pins_d)
  );

  sdram_wr_beat_ctr #(.BURST_LEN(BURST_LEN)) u_ctr (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .more_beats (more_beats),
    .last_beat  (last_beat)
  );

  sdram_wr_close_trk #(.BANK_W(BANK_W)) u_close (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .start_bank  (req_bank),
    .start_ap    (req_autopre),
    .last_beat   (last_beat),
    .close_valid (ap_close_valid),
    .close_bank  (ap_close_bank)
  );

  always_comb begin
    addr_d               = '0;
    addr_d[COL_W-1:0]    = req_col;
    addr_d[AP_BIT]       = req_autopre;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pins_q    <= PINS_NOP;
      sd_ba     <= '0;
      sd_addr   <= '0;
      sd_dq_out <= '0;
      sd_dq_oe  <= 1'b0;
    end else begin
      pins_q <= pins_d;
      if (start) begin
        sd_ba     <= req_bank;
        sd_addr   <= addr_d;
        sd_dq_out <= dat_word;
        sd_dq_oe  <= 1'b1;
      end else if (more_beats) begin
        sd_dq_oe <= dat_valid;
        if (dat_valid) sd_dq_out <= dat_word;
      end else begin
        sd_dq_oe <= 1'b0;
      end
    end
  end

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = pins_q;

  a_r2_write_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == PINS_WRITE));

  a_r2_write_carries_data: assert property (@(posedge clk) disable iff (!rst_n)
    ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == PINS_WRITE) |-> sd_dq_oe);

  a_r4_idle_bus_released: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !more_beats) |=> !sd_dq_oe);

  a_r7_close_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    ap_close_valid |-> $past(last_beat));
endmodule

// File: tb/test_sdram_wr_seq.sv
`timescale 1ns/1ps
module test_sdram_wr_seq;
  localparam logic [3:0] NOP = 4'b0111;
  localparam logic [3:0] WR  = 4'b0100;

  typedef struct packed {
    logic        rv;
    logic        dv;
    logic [1:0]  bank;
    logic [8:0]  col;
    logic        ap;
    logic [15:0] w;
    logic        e_rr;
    logic        e_dr;
    logic [3:0]  e_pins;
    logic        e_oe;
    logic [15:0] e_dq;
    logic        e_cls;
    logic [1:0]  e_cb;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b0,2'd0,9'h000,1'b0,16'h0000, 1'b0,1'b0,NOP,1'b0,16'h0000,1'b0,2'd0}, // R1 idle
    '{1'b1,1'b0,2'd1,9'h005,1'b0,16'h0000, 1'b0,1'b1,NOP,1'b0,16'h0000,1'b0,2'd0}, // R9 stall
    '{1'b1,1'b1,2'd1,9'h005,1'b0,16'hA001, 1'b1,1'b1,WR ,1'b1,16'hA001,1'b0,2'd0}, // R2
    '{1'b0,1'b1,2'd0,9'h000,1'b0,16'hA002, 1'b1,1'b1,NOP,1'b1,16'hA002,1'b0,2'd0}, // R3
    '{1'b0,1'b1,2'd0,9'h000,1'b0,16'hA003, 1'b1,1'b1,NOP,1'b1,16'hA003,1'b0,2'd0},
    '{1'b0,1'b1,2'd0,9'h000,1'b0,16'hA004, 1'b1,1'b1,NOP,1'b1,16'hA004,1'b0,2'd0},
    '{1'b0,1'b1,2'd0,9'h000,1'b0,16'hDEAD, 1'b1,1'b0,NOP,1'b0,16'h0000,1'b0,2'd0}, // R4 ignored
    '{1'b1,1'b1,2'd2,9'h1F0,1'b1,16'hB001, 1'b1,1'b1,WR ,1'b1,16'hB001,1'b0,2'd0}, // R7 ap burst
    '{1'b0,1'b1,2'd0,9'h000,1'b0,16'hB002, 1'b1,1'b1,NOP,1'b1,16'hB002,1'b0,2'd0},
    '{1'b0,1'b1,2'd0,9'h000,1'b0,16'hB003, 1'b1,1'b1,NOP,1'b1,16'hB003,1'b0,2'd0},
    '{1'b0,1'b1,2'd0,9'h000,1'b0,16'hB004, 1'b1,1'b1,NOP,1'b1,16'hB004,1'b0,2'd0},
    '{1'b0,1'b0,2'd0,9'h000,1'b0,16'h0000, 1'b0,1'b0,NOP,1'b0,16'h0000,1'b1,2'd2}, // R7 close
    '{1'b0,1'b0,2'd0,9'h000,1'b0,16'h0000, 1'b0,1'b0,NOP,1'b0,16'h0000,1'b0,2'd0},
    '{1'b1,1'b1,2'd0,9'h010,1'b1,16'hC001, 1'b1,1'b1,WR ,1'b1,16'hC001,1'b0,2'd0},
    '{1'b0,1'b1,2'd0,9'h000,1'b0,16'hC002, 1'b1,1'b1,NOP,1'b1,16'hC002,1'b0,2'd0},
    '{1'b1,1'b1,2'd3,9'h020,1'b0,16'hD001, 1'b1,1'b1,WR ,1'b1,16'hD001,1'b0,2'd0}, // R5 truncate
    '{1'b0,1'b1,2'd0,9'h000,1'b0,16'hD002, 1'b1,1'b1,NOP,1'b1,16'hD002,1'b0,2'd0},
    '{1'b0,1'b1,2'd0,9'h000,1'b0,16'hD003, 1'b1,1'b1,NOP,1'b1,16'hD003,1'b0,2'd0},
    '{1'b0,1'b1,2'd0,9'h000,1'b0,16'hD004, 1'b1,1'b1,NOP,1'b1,16'hD004,1'b0,2'd0}, // R5 full count
    '{1'b1,1'b1,2'd1,9'h030,1'b1,16'hE001, 1'b1,1'b1,WR ,1'b1,16'hE001,1'b0,2'd0}, // R6 no gap
    '{1'b0,1'b1,2'd0,9'h000,1'b0,16'hE002, 1'b1,1'b1,NOP,1'b1,16'hE002,1'b0,2'd0},
    '{1'b0,1'b0,2'd0,9'h000,1'b0,16'h0000, 1'b0,1'b1,NOP,1'b0,16'h0000,1'b0,2'd0}, // R8 starved
    '{1'b0,1'b1,2'd0,9'h000,1'b0,16'hE004, 1'b1,1'b1,NOP,1'b1,16'hE004,1'b0,2'd0}, // R8 last beat
    '{1'b0,1'b0,2'd0,9'h000,1'b0,16'h0000, 1'b0,1'b0,NOP,1'b0,16'h0000,1'b1,2'd1}, // R8 end on time
    '{1'b0,1'b0,2'd0,9'h000,1'b0,16'h0000, 1'b0,1'b0,NOP,1'b0,16'h0000,1'b0,2'd0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_bank = '0;
  logic [8:0]  req_col = '0;
  logic        req_autopre = 1'b0;
  logic        dat_valid = 1'b0;
  logic        dat_ready;
  logic [15:0] dat_word = '0;
  logic        sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
  logic [1:0]  sd_ba;
  logic [12:0] sd_addr;
  logic [15:0] sd_dq_out;
  logic        sd_dq_oe;
  logic        ap_close_valid;
  logic [1:0]  ap_close_bank;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sdram_wr_seq i_sdram_wr_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_bank(req_bank),
    .req_col(req_col), .req_autopre(req_autopre),
    .dat_valid(dat_valid), .dat_ready(dat_ready), .dat_word(dat_word),
    .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
    .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr),
    .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe),
    .ap_close_valid(ap_close_valid), .ap_close_bank(ap_close_bank)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] pins();
    return {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
  endfunction

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    chk("R1 pins in reset", 32'(pins()), 32'(NOP));
    chk("R1 oe in reset", 32'(sd_dq_oe), 32'd0);
    chk("R1 close in reset", 32'(ap_close_valid), 32'd0);
    chk("R10 cke", 32'(sd_cke), 32'd1);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 pins after reset", 32'(pins()), 32'(NOP));

    // vector walk
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      req_valid   = VEC[i].rv;
      dat_valid   = VEC[i].dv;
      req_bank    = VEC[i].bank;
      req_col     = VEC[i].col;
      req_autopre = VEC[i].ap;
      dat_word    = VEC[i].w;
      #1;
      chk("R9 req_ready", 32'(req_ready), 32'(VEC[i].e_rr));
      chk("R4 dat_ready", 32'(dat_ready), 32'(VEC[i].e_dr));
      @(posedge clk); #1;
      chk("R2 pins", 32'(pins()), 32'(VEC[i].e_pins));
      chk("R3 oe", 32'(sd_dq_oe), 32'(VEC[i].e_oe));
      if (VEC[i].e_oe) chk("R3 data", 32'(sd_dq_out), 32'(VEC[i].e_dq));
      if (VEC[i].e_pins == WR) begin
        chk("R2 bank", 32'(sd_ba), 32'(VEC[i].bank));
        chk("R2 addr", 32'(sd_addr), 32'(VEC[i].col) | (32'(VEC[i].ap) << 10));
      end
      chk("R7 close", 32'(ap_close_valid), 32'(VEC[i].e_cls));
      if (VEC[i].e_cls) chk("R7 close bank", 32'(ap_close_bank), 32'(VEC[i].e_cb));
      chk("R10 cke", 32'(sd_cke), 32'd1);
    end

    // R1: reset in the middle of a burst
    @(negedge clk);
    req_valid = 1'b1; dat_valid = 1'b1; req_bank = 2'd3; req_col = 9'h0AA;
    req_autopre = 1'b1; dat_word = 16'hF001;
    @(posedge clk); #1;
    chk("R2 pins before reset", 32'(pins()), 32'(WR));
    @(negedge clk);
    req_valid = 1'b0; dat_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    chk("R1 oe after mid-burst reset", 32'(sd_dq_oe), 32'd0);
    chk("R1 pins after mid-burst reset", 32'(pins()), 32'(NOP));
    @(negedge clk);
    rst_n = 1'b1;
    repeat (5) begin
      @(posedge clk); #1;
      chk("R7 no close after reset", 32'(ap_close_valid), 32'd0);
      chk("R1 bus idle after reset", 32'(sd_dq_oe), 32'd0);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule